// File: doc/BRIEF.md
# Indirect Interrupt-Configuration Window

This block sits behind a select/data pair of indirect registers and turns each 32-bit access into operations on per-interrupt configuration state that it holds itself. A 12-bit select value picks a region and a group within it, and a 2-bit data index picks which field of that group is seen.

In the low select range, one word gathers a single byte from four neighbouring interrupts: either their control bytes or their attribute bytes. In the next range, one word packs the pending or the enable flags of 32 consecutive interrupts. A small range above that reaches whole 32-bit trigger registers. Everything else reads as zero and drops writes.

Writes scatter in the same way. Control bytes have their unimplemented low bits forced to one. Pending flags change only for interrupts whose attribute marks them edge-sensitive. Interrupt numbers at or above the configured count do not exist. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_csr_window`

## Requirements
- R1: A read strobe sampled at a clock edge gives `csr_rdata` and `csr_rvalid`=1 after that edge; `csr_rvalid` is 0 after any edge where the read strobe was low.
- R2: For select values below 0x400, byte lane k (bits 8k+7..8k) of the word belongs to interrupt 4*select+k; index 0 reaches the control bytes and index 1 the attribute bytes. Both are read and written whole.
- R3: A control-byte write stores the byte with its low 8-CTL_BITS bits forced to 1 (with CTL_BITS=4, the low nibble reads 0xF).
- R4: For select values 0x400 to 0x47F, bit b of the word belongs to interrupt 32*(select-0x400)+b; index 0 reaches the pending flags and index 1 the enable flags.
- R5: A pending-flag write changes only interrupts whose attribute bit 1 (edge-sensitive) is 1; the flags of level-sensitive interrupts keep their value.
- R6: Select 0x480+j with index 0 reads and writes the 32-bit trigger register j when j < N_TRIG; when j >= N_TRIG it reads 0 and writes are dropped.
- R7: In the trigger range, index 1 reads 0 and writes have no effect on any trigger register.
- R8: Select values of 0x4A0 and above, and index values 2 and 3 at any select, read 0 and writes change no state.
- R9: Bytes and bits that fall on interrupt numbers >= N_IRQ read 0 and ignore writes.
- R10: After reset, control bytes read 0xFF, attribute bytes 0xC0, and pending, enable and trigger state 0; `csr_rdata` is 0 and `csr_rvalid` is 0.
- R11: A read and a write in the same cycle to the same location return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 12 | Indirect select value |
| csr_idx | input | 2 | Data-register index |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| csr_rvalid | output | 1 | Read data valid, one cycle after `csr_rd` |

## Verification
The configuration state is visible only through later reads. A wrong lane-to-interrupt mapping or a misdecoded range therefore shows up as a displaced or missing byte or bit in the read that follows the write, one cycle after the read strobe. Every write in the stimulus is followed by a read of the same location, and by reads of the neighbouring group or the index that must not have been touched. A pending write that is not gated, or a control write whose low bits are not forced, returns a value that differs in specific bits from the value computed from the requirements.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CA   = 2'd1,
    RG_PE   = 2'd2,
    RG_TRIG = 2'd3
  } region_t;

  localparam int SEL_W  = 12;
  localparam int DATA_W = 32;
endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
  import iwin_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       idx,
  output region_t          region
);
  logic idx_ok;
  assign idx_ok = (idx <= 2'd1);

  always_comb begin
    region = RG_NONE;
    if (idx_ok) begin
      if (sel[11:10] == 2'b00)
        region = RG_CA;
      else if (sel[11:7] == 5'b01000)
        region = RG_PE;
      else if (sel[11:5] == 7'b0100100 && idx == 2'd0)
        region = RG_TRIG;
    end
  end
endmodule

// File: rtl/iwin_irq_store.sv
module iwin_irq_store
  import iwin_pkg::*;
#(
  parameter int N_IRQ    = 38,
  parameter int CTL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  region_t           region,
  input  logic              fsel,
  input  logic [9:0]        grp_a,
  input  logic [6:0]        grp_p,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [7:0] FORCE_ONES = 8'((1 << (8 - CTL_BITS)) - 1);
  localparam logic [7:0] CTL_RST    = 8'hFF;
  localparam logic [7:0] ATTR_RST   = 8'hC0;

  logic [DATA_W-1:0] part [N_IRQ];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    localparam int         LA = i % 4;
    localparam int         LP = i % 32;
    localparam logic [9:0] GA = 10'(i / 4);
    localparam logic [6:0] GP = 7'(i / 32);

    logic       hit_a, hit_p;
    logic [7:0] ctl_q, attr_q;
    logic       pend_q, en_q;

    assign hit_a = (region == RG_CA) && (grp_a == GA);
    assign hit_p = (region == RG_PE) && (grp_p == GP);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q  <= CTL_RST;
        attr_q <= ATTR_RST;
        pend_q <= 1'b0;
        en_q   <= 1'b0;
      end else if (wr_en) begin
        if (hit_a) begin
          if (fsel) attr_q <= wdata[8*LA +: 8];
          else      ctl_q  <= wdata[8*LA +: 8] | FORCE_ONES;
        end
        if (hit_p) begin
          if (fsel)           en_q   <= wdata[LP];
          else if (attr_q[1]) pend_q <= wdata[LP];
        end
      end
    end

    always_comb begin
      part[i] = '0;
      if (hit_a)
        part[i] = DATA_W'(fsel ? attr_q : ctl_q) << (8 * LA);
      else if (hit_p)
        part[i] = DATA_W'(fsel ? en_q : pend_q) << LP;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_IRQ; i++) rdata |= part[i];
  end
endmodule

// File: rtl/iwin_trig_bank.sv
module iwin_trig_bank
  import iwin_pkg::*;
#(
  parameter int N_TRIG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  region_t           region,
  input  logic [4:0]        slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] trig_q [N_TRIG];

  for (genvar j = 0; j < N_TRIG; j++) begin : g_trig
    always_ff @(posedge clk) begin
      if (rst)
        trig_q[j] <= '0;
      else if (wr_en && region == RG_TRIG && slot == 5'(j))
        trig_q[j] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (region == RG_TRIG)
      for (int j = 0; j < N_TRIG; j++)
        if (slot == 5'(j)) rdata = trig_q[j];
  end
endmodule

// File: rtl/irq_csr_window.sv
module irq_csr_window
  import iwin_pkg::*;
#(
  parameter int N_IRQ    = 38,
  parameter int CTL_BITS = 4,
  parameter int N_TRIG   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] csr_sel,
  input  logic [1:0]  csr_idx,
  input  logic        csr_rd,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        csr_rvalid
);
  region_t           region;
  logic [DATA_W-1:0] store_rd, trig_rd;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  iwin_decode dec_i (
    .sel    (csr_sel),
    .idx    (csr_idx),
    .region (region)
  );

  iwin_irq_store #(.N_IRQ(N_IRQ), .CTL_BITS(CTL_BITS)) store_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (csr_wr),
    .region (region),
    .fsel   (csr_idx[0]),
    .grp_a  (csr_sel[9:0]),
    .grp_p  (csr_sel[6:0]),
    .wdata  (csr_wdata),
    .rdata  (store_rd)
  );

  iwin_trig_bank #(.N_TRIG(N_TRIG)) trig_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (csr_wr),
    .region (region),
    .slot   (csr_sel[4:0]),
    .wdata  (csr_wdata),
    .rdata  (trig_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= csr_rd;
      if (csr_rd) begin
        unique case (region)
          RG_CA, RG_PE: rdata_q <= store_rd;
          RG_TRIG:      rdata_q <= trig_rd;
          default:      rdata_q <= '0;
        endcase
      end
    end
  end

  assign csr_rdata  = rdata_q;
  assign csr_rvalid = rvalid_q;
endmodule

// File: rtl/irq_csr_window_chk.sv
module irq_csr_window_chk #(
  parameter int N_IRQ    = 38,
  parameter int CTL_BITS = 4
) (
  input logic        clk,
  input logic        rst,
  input logic [11:0] csr_sel,
  input logic [1:0]  csr_idx,
  input logic        csr_rd,
  input logic [31:0] csr_rdata,
  input logic        csr_rvalid
);
  localparam logic [7:0]  LOW8 = 8'((1 << (8 - CTL_BITS)) - 1);
  localparam logic [31:0] LOWM = {4{LOW8}};

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (csr_rdata == 32'd0 && !csr_rvalid));

  p_valid_after_rd_r1: assert property (@(posedge clk) disable iff (rst)
    csr_rd |=> csr_rvalid);

  p_no_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !csr_rd |=> !csr_rvalid);

  p_bad_idx_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_idx > 2'd1) |=> csr_rdata == 32'd0);

  p_reserved_sel_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_sel >= 12'h4A0) |=> csr_rdata == 32'd0);

  p_trig_idx1_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_idx == 2'd1 && csr_sel >= 12'h480 && csr_sel < 12'h4A0)
      |=> csr_rdata == 32'd0);

  p_ctl_low_ones_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_idx == 2'd0 && int'(csr_sel) < N_IRQ / 4)
      |=> (csr_rdata & LOWM) == LOWM);

  p_beyond_count_r9: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && csr_idx <= 2'd1 && csr_sel >= 12'h400 && csr_sel < 12'h480 &&
     (int'(csr_sel) - 'h400) * 32 >= N_IRQ) |=> csr_rdata == 32'd0);
endmodule

bind irq_csr_window irq_csr_window_chk #(.N_IRQ(N_IRQ), .CTL_BITS(CTL_BITS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .csr_sel    (csr_sel),
  .csr_idx    (csr_idx),
  .csr_rd     (csr_rd),
  .csr_rdata  (csr_rdata),
  .csr_rvalid (csr_rvalid)
);

// File: tb/irq_csr_window_tb_top.sv
module irq_csr_window_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_sel = '0;
  logic [1:0]  csr_idx = '0;
  logic        csr_rd = 1'b0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_csr_window #(.N_IRQ(38), .CTL_BITS(4), .N_TRIG(4)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .csr_sel    (csr_sel),
    .csr_idx    (csr_idx),
    .csr_rd     (csr_rd),
    .csr_wr     (csr_wr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .csr_rvalid (csr_rvalid)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] sel;
    logic [1:0]  idx;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 12'h000, 2'd0, 32'h0,        32'hFFFFFFFF, 8'd10}, // R10 ctl reset
    '{1'b0, 1'b1, 12'h000, 2'd1, 32'h0,        32'hC0C0C0C0, 8'd10}, // R10 attr reset
    '{1'b0, 1'b1, 12'h400, 2'd0, 32'h0,        32'h00000000, 8'd10}, // R10 pending reset
    '{1'b1, 1'b0, 12'h000, 2'd0, 32'h12345678, 32'h0,        8'd3},  // R3 ctl write
    '{1'b0, 1'b1, 12'h000, 2'd0, 32'h0,        32'h1F3F5F7F, 8'd3},  // R3 low nibble forced
    '{1'b1, 1'b0, 12'h001, 2'd1, 32'h02020002, 32'h0,        8'd2},  // R2 attr irq4..7
    '{1'b0, 1'b1, 12'h001, 2'd1, 32'h0,        32'h02020002, 8'd2},  // R2 attr lanes
    '{1'b1, 1'b0, 12'h400, 2'd0, 32'hFFFFFFFF, 32'h0,        8'd5},  // R5 pending all ones
    '{1'b0, 1'b1, 12'h400, 2'd0, 32'h0,        32'h000000D0, 8'd5},  // R5 only edge irqs 4,6,7
    '{1'b1, 1'b0, 12'h400, 2'd1, 32'hA5A5A5A5, 32'h0,        8'd4},  // R4 enable write
    '{1'b0, 1'b1, 12'h400, 2'd1, 32'h0,        32'hA5A5A5A5, 8'd4},  // R4 enable read
    '{1'b1, 1'b0, 12'h401, 2'd1, 32'hFFFFFFFF, 32'h0,        8'd9},  // R9 enable irq32..63
    '{1'b0, 1'b1, 12'h401, 2'd1, 32'h0,        32'h0000003F, 8'd9},  // R9 only 32..37 exist
    '{1'b1, 1'b0, 12'h009, 2'd0, 32'h00000000, 32'h0,        8'd9},  // R9 ctl irq36..39
    '{1'b0, 1'b1, 12'h009, 2'd0, 32'h0,        32'h00000F0F, 8'd9},  // R9 lanes 2,3 absent
    '{1'b0, 1'b1, 12'h00A, 2'd1, 32'h0,        32'h00000000, 8'd9},  // R9 group beyond count
    '{1'b1, 1'b0, 12'h481, 2'd0, 32'hCAFEF00D, 32'h0,        8'd6},  // R6 trig1 write
    '{1'b0, 1'b1, 12'h481, 2'd0, 32'h0,        32'hCAFEF00D, 8'd6},  // R6 trig1 read
    '{1'b0, 1'b1, 12'h480, 2'd0, 32'h0,        32'h00000000, 8'd6},  // R6 trig0 untouched
    '{1'b1, 1'b0, 12'h484, 2'd0, 32'h11111111, 32'h0,        8'd6},  // R6 slot past N_TRIG
    '{1'b0, 1'b1, 12'h484, 2'd0, 32'h0,        32'h00000000, 8'd6},  // R6 reads zero
    '{1'b1, 1'b0, 12'h481, 2'd1, 32'h00000000, 32'h0,        8'd7},  // R7 idx1 write
    '{1'b0, 1'b1, 12'h481, 2'd1, 32'h0,        32'h00000000, 8'd7},  // R7 idx1 reads zero
    '{1'b0, 1'b1, 12'h481, 2'd0, 32'h0,        32'hCAFEF00D, 8'd7},  // R7 trig1 kept
    '{1'b1, 1'b0, 12'h4A0, 2'd0, 32'hFFFFFFFF, 32'h0,        8'd8},  // R8 reserved write
    '{1'b0, 1'b1, 12'h4A0, 2'd0, 32'h0,        32'h00000000, 8'd8},  // R8 reserved read
    '{1'b1, 1'b0, 12'h000, 2'd2, 32'h00000000, 32'h0,        8'd8},  // R8 idx2 write
    '{1'b0, 1'b1, 12'h000, 2'd2, 32'h0,        32'h00000000, 8'd8},  // R8 idx2 reads zero
    '{1'b0, 1'b1, 12'h000, 2'd0, 32'h0,        32'h1F3F5F7F, 8'd8},  // R8 ctl kept
    '{1'b1, 1'b0, 12'h400, 2'd3, 32'h00000000, 32'h0,        8'd8},  // R8 idx3 write
    '{1'b0, 1'b1, 12'h400, 2'd0, 32'h0,        32'h000000D0, 8'd8},  // R8 pending kept
    '{1'b0, 1'b1, 12'hFFF, 2'd0, 32'h0,        32'h00000000, 8'd8},  // R8 top select
    '{1'b1, 1'b1, 12'h001, 2'd1, 32'h00000000, 32'h02020002, 8'd11}, // R11 old value
    '{1'b0, 1'b1, 12'h001, 2'd1, 32'h0,        32'h00000000, 8'd11}  // R11 new value
  };

  task automatic check(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after the result edge
  task automatic op(input logic w, input logic r, input logic [11:0] s,
                    input logic [1:0] x, input logic [31:0] d);
    csr_wr = w; csr_rd = r; csr_sel = s; csr_idx = x; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: registered outputs cleared by reset
    check(csr_rdata == 32'd0, 10, csr_rdata, 32'd0);
    check(csr_rvalid == 1'b0, 10, 32'(csr_rvalid), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      op(VT[v].wr, VT[v].rd, VT[v].sel, VT[v].idx, VT[v].wd);
      // R1: valid exactly when a read was issued
      check(csr_rvalid == VT[v].rd, 1, 32'(csr_rvalid), 32'(VT[v].rd));
      if (VT[v].rd)
        check(csr_rdata == VT[v].ex, int'(VT[v].req), csr_rdata, VT[v].ex);
    end

    // R1: idle cycle drops valid and holds data
    @(negedge clk);
    check(csr_rvalid == 1'b0, 1, 32'(csr_rvalid), 32'd0);

    // R10: reset restores every kind of state
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(csr_rvalid == 1'b0 && csr_rdata == 32'd0, 10, csr_rdata, 32'd0);
    rst = 1'b0;
    op(1'b0, 1'b1, 12'h481, 2'd0, 32'h0);
    check(csr_rdata == 32'h0, 10, csr_rdata, 32'h0);
    op(1'b0, 1'b1, 12'h400, 2'd1, 32'h0);
    check(csr_rdata == 32'h0, 10, csr_rdata, 32'h0);
    op(1'b0, 1'b1, 12'h000, 2'd0, 32'h0);
    check(csr_rdata == 32'hFFFFFFFF, 10, csr_rdata, 32'hFFFFFFFF);
    op(1'b0, 1'b1, 12'h001, 2'd1, 32'h0);
    check(csr_rdata == 32'hC0C0C0C0, 10, csr_rdata, 32'hC0C0C0C0);

    // R5: level irq stays clear after reset, edge irq accepts a clear
    op(1'b1, 1'b0, 12'h000, 2'd1, 32'h00000200);
    op(1'b1, 1'b0, 12'h400, 2'd0, 32'h00000003);
    op(1'b0, 1'b1, 12'h400, 2'd0, 32'h0);
    check(csr_rdata == 32'h00000002, 5, csr_rdata, 32'h00000002);
    op(1'b1, 1'b0, 12'h400, 2'd0, 32'h00000000);
    op(1'b0, 1'b1, 12'h400, 2'd0, 32'h0);
    check(csr_rdata == 32'h00000000, 5, csr_rdata, 32'h00000000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule